// File: doc/BRIEF.md
# Privilege-Based Pointer Masking Unit

This block produces the effective address for instruction fetches and for data accesses when pointer masking is in use. Software programs a small control word plus one mask and one base value for each of the three privilege levels (machine, supervisor, user) through a single-cycle write port. The unit holds the current privilege and register contents in a set of active registers: an active mask, an active base, a data-masking enable and an instruction-masking flag.

A raw address is rewritten as `(addr AND NOT mask) OR base` when masking applies to it. When masking does not apply, the address passes through unchanged in 64-bit mode. In 32-bit mode it is cut to its low 32 bits. Fetch addresses are masked only when the current level's instruction bit is set. Data addresses are masked whenever the current level is enabled. The adjusted addresses are combinational from the raw inputs and the active registers. Those registers take the values of the register writes and the privilege input seen at each clock edge.

Top module: `ptr_mask_unit`

## Requirements
- R1: After a synchronous reset the control word reads 0 and all masks and bases are 0. No level is enabled, so both addresses pass through unchanged in 64-bit mode.
- R2: A write with select 0 stores write-data bits [5:0] into the control word: bit 0/1/2 enable machine/supervisor/user, and bit 3/4/5 are the instruction-masking bits of machine/supervisor/user. The same write forces bit 6 (machine "current") to 1 and sets bit 7 (dirty). The instruction-masking bits read back as written.
- R3: When the current level is enabled and its instruction bit is set, the fetch address is `(pc AND NOT mask) OR base`, using that level's own mask and base.
- R4: When the current level is enabled but its instruction bit is clear, the data address is masked while the fetch address is not.
- R5: When the current level is not enabled, neither address is masked. The active mask is all ones and the active base is zero.
- R6: When an address is not masked, 32-bit mode (`xlen32_i`=1) clears its bits above 31, and 64-bit mode passes it unchanged.
- R7: When an address is masked in 32-bit mode, no truncation is applied: base bits above 31 reach the output.
- R8: Privilege encoding 2'b10 (unsupported) behaves as a disabled level. The other encodings are 2'b11 machine, 2'b01 supervisor and 2'b00 user.
- R9: A register write and the privilege input sampled at a clock edge are both reflected in the addresses from that edge on.
- R10: A write with select 7 changes no register and has no effect on the control word or on the addresses.
- R11: Selects 1/2/3 write the machine/supervisor/user mask and selects 4/5/6 write the machine/supervisor/user base. A write to one level leaves the other levels' values intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select for the write |
| cfg_wdata | input | XLEN | Write data |
| priv_i | input | 2 | Current privilege level |
| xlen32_i | input | 1 | 1 = 32-bit mode, 0 = 64-bit mode |
| pc_i | input | XLEN | Raw fetch address |
| data_addr_i | input | XLEN | Raw data address |
| ctl_o | output | 8 | Control word contents |
| fetch_addr_o | output | XLEN | Adjusted fetch address |
| data_addr_o | output | XLEN | Adjusted data address |

## Verification
The bench targets the split between the two address paths: an enabled level with a clear instruction bit must mask data but not fetches. A design that tied the two paths to one flag would mask the program counter as well. In 32-bit mode with masking active, the bench places base bits above 31 and expects them on the output; a design that truncated unconditionally would drop them. The bench writes one level's mask and then runs at another level, which catches a design that decodes selects or privilege onto the wrong level. It also checks the unsupported privilege code and select 7, which must neither mask nor store anything. Writes issued together with privilege changes in the same cycle expose a design whose active registers lag by an extra edge.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [1:0] {
    PRIV_USER = 2'b00,
    PRIV_SUPV = 2'b01,
    PRIV_RSVD = 2'b10,
    PRIV_MACH = 2'b11
  } priv_e;

  localparam int LVL_N     = 3;   // level index: 0 machine, 1 supervisor, 2 user
  localparam int CTL_W     = 8;
  localparam int EN_LSB    = 0;
  localparam int IF_LSB    = 3;
  localparam int MCUR_BIT  = 6;
  localparam int DIRTY_BIT = 7;

  localparam logic [2:0] SEL_CTL   = 3'd0;
  localparam logic [2:0] SEL_MASK0 = 3'd1;
  localparam logic [2:0] SEL_BASE0 = 3'd4;

  typedef struct packed {
    logic       valid;
    logic [1:0] idx;
  } lvl_t;

  function automatic lvl_t priv_to_lvl(input logic [1:0] p);
    lvl_t r;
    r.valid = 1'b1;
    case (p)
      PRIV_MACH: r.idx = 2'd0;
      PRIV_SUPV: r.idx = 2'd1;
      PRIV_USER: r.idx = 2'd2;
      default: begin
        r.valid = 1'b0;
        r.idx   = 2'd0;
      end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pm_cfg_regs.sv
module pm_cfg_regs
  import pm_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [2:0]             wr_sel,
  input  logic [XLEN-1:0]        wr_data,
  output logic [CTL_W-1:0]       ctl_q,
  output logic [CTL_W-1:0]       ctl_nxt,
  output logic [XLEN-1:0]        mask_nxt [LVL_N],
  output logic [XLEN-1:0]        base_nxt [LVL_N]
);
  logic [XLEN-1:0] mask_q [LVL_N];
  logic [XLEN-1:0] base_q [LVL_N];

  always_comb begin
    ctl_nxt = ctl_q;
    if (wr_en && wr_sel == SEL_CTL) begin
      ctl_nxt                         = '0;
      ctl_nxt[IF_LSB+LVL_N-1:EN_LSB]  = wr_data[IF_LSB+LVL_N-1:EN_LSB];
      ctl_nxt[MCUR_BIT]               = 1'b1;
      ctl_nxt[DIRTY_BIT]              = 1'b1;
    end
  end

  for (genvar g = 0; g < LVL_N; g++) begin : g_lvl
    always_comb begin
      mask_nxt[g] = mask_q[g];
      base_nxt[g] = base_q[g];
      if (wr_en && wr_sel == SEL_MASK0 + 3'(g)) mask_nxt[g] = wr_data;
      if (wr_en && wr_sel == SEL_BASE0 + 3'(g)) base_nxt[g] = wr_data;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q[g] <= '0;
        base_q[g] <= '0;
      end else begin
        mask_q[g] <= mask_nxt[g];
        base_q[g] <= base_nxt[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ctl_q <= '0;
    else     ctl_q <= ctl_nxt;
  end
endmodule

// File: rtl/pm_select.sv
module pm_select
  import pm_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [1:0]       priv,
  input  logic [CTL_W-1:0] ctl,
  input  logic [XLEN-1:0]  mask [LVL_N],
  input  logic [XLEN-1:0]  base [LVL_N],
  output logic             sel_en,
  output logic             sel_if,
  output logic [XLEN-1:0]  sel_mask,
  output logic [XLEN-1:0]  sel_base
);
  lvl_t lvl;

  always_comb begin
    lvl      = priv_to_lvl(priv);
    sel_en   = 1'b0;
    sel_if   = 1'b0;
    sel_mask = '1;
    sel_base = '0;
    if (lvl.valid && ctl[EN_LSB + int'(lvl.idx)]) begin
      sel_en   = 1'b1;
      sel_if   = ctl[IF_LSB + int'(lvl.idx)];
      sel_mask = mask[lvl.idx];
      sel_base = base[lvl.idx];
    end
  end
endmodule

// File: rtl/pm_xform.sv
module pm_xform #(
  parameter int XLEN   = 64,
  parameter int NARROW = 32
) (
  input  logic [XLEN-1:0] addr,
  input  logic [XLEN-1:0] mask,
  input  logic [XLEN-1:0] base,
  input  logic            apply,
  input  logic            narrow,
  output logic [XLEN-1:0] result
);
  localparam logic [XLEN-1:0] LOW_KEEP = XLEN'({NARROW{1'b1}});

  always_comb begin
    if (apply)       result = (addr & ~mask) | base;
    else if (narrow) result = addr & LOW_KEEP;
    else             result = addr;
  end
endmodule

// File: rtl/ptr_mask_unit.sv
module ptr_mask_unit
  import pm_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [2:0]      cfg_sel,
  input  logic [XLEN-1:0] cfg_wdata,
  input  logic [1:0]      priv_i,
  input  logic            xlen32_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] data_addr_i,
  output logic [7:0]      ctl_o,
  output logic [XLEN-1:0] fetch_addr_o,
  output logic [XLEN-1:0] data_addr_o
);
  logic [CTL_W-1:0] ctl_q, ctl_nxt;
  logic [XLEN-1:0]  mask_nxt [LVL_N];
  logic [XLEN-1:0]  base_nxt [LVL_N];
  logic             nx_en, nx_if;
  logic [XLEN-1:0]  nx_mask, nx_base;
  logic             act_en_q, act_if_q;
  logic [XLEN-1:0]  act_mask_q, act_base_q;

  pm_cfg_regs #(.XLEN(XLEN)) u_regs (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_sel(cfg_sel), .wr_data(cfg_wdata),
    .ctl_q(ctl_q), .ctl_nxt(ctl_nxt), .mask_nxt(mask_nxt), .base_nxt(base_nxt)
  );

  pm_select #(.XLEN(XLEN)) u_sel (
    .priv(priv_i), .ctl(ctl_nxt), .mask(mask_nxt), .base(base_nxt),
    .sel_en(nx_en), .sel_if(nx_if), .sel_mask(nx_mask), .sel_base(nx_base)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      act_en_q   <= 1'b0;
      act_if_q   <= 1'b0;
      act_mask_q <= '1;
      act_base_q <= '0;
    end else begin
      act_en_q   <= nx_en;
      act_if_q   <= nx_if;
      act_mask_q <= nx_mask;
      act_base_q <= nx_base;
    end
  end

  pm_xform #(.XLEN(XLEN)) u_fetch (
    .addr(pc_i), .mask(act_mask_q), .base(act_base_q),
    .apply(act_if_q), .narrow(xlen32_i), .result(fetch_addr_o)
  );

  pm_xform #(.XLEN(XLEN)) u_data (
    .addr(data_addr_i), .mask(act_mask_q), .base(act_base_q),
    .apply(act_en_q), .narrow(xlen32_i), .result(data_addr_o)
  );

  assign ctl_o = ctl_q;
endmodule

// File: rtl/pm_unit_chk.sv
module pm_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            cfg_we,
  input logic [2:0]      cfg_sel,
  input logic [XLEN-1:0] cfg_wdata,
  input logic [1:0]      priv_i,
  input logic            xlen32_i,
  input logic [XLEN-1:0] pc_i,
  input logic [XLEN-1:0] data_addr_i,
  input logic [7:0]      ctl_o,
  input logic [XLEN-1:0] fetch_addr_o,
  input logic [XLEN-1:0] data_addr_o
);
  localparam logic [XLEN-1:0] LOW32 = XLEN'({32{1'b1}});

  // R2
  ctl_write_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_sel == 3'd0) |=>
      (ctl_o[7:6] == 2'b11 && ctl_o[5:0] == $past(cfg_wdata[5:0])));

  // R10
  ctl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(cfg_we && cfg_sel == 3'd0) |=> $stable(ctl_o));

  // R8
  rsvd_priv_chk: assert property (@(posedge clk) disable iff (rst)
    (priv_i == 2'b10) |=>
      (fetch_addr_o == (xlen32_i ? (pc_i & LOW32) : pc_i) &&
       data_addr_o  == (xlen32_i ? (data_addr_i & LOW32) : data_addr_i)));

  // R6
  narrow_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_o[5:3] == 3'b000 && xlen32_i) |-> (fetch_addr_o[XLEN-1:32] == '0));

  // R5
  all_off_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_o[2:0] == 3'b000 && !xlen32_i) |->
      (fetch_addr_o == pc_i && data_addr_o == data_addr_i));
endmodule

bind ptr_mask_unit pm_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
  .priv_i(priv_i), .xlen32_i(xlen32_i), .pc_i(pc_i), .data_addr_i(data_addr_i),
  .ctl_o(ctl_o), .fetch_addr_o(fetch_addr_o), .data_addr_o(data_addr_o)
);

// File: tb/test_ptr_mask_unit.sv
module test_ptr_mask_unit;
  localparam int XLEN = 64;
  localparam logic [63:0] LOW32 = 64'h0000_0000_FFFF_FFFF;

  logic            clk = 1'b0;
  logic            rst;
  logic            cfg_we;
  logic [2:0]      cfg_sel;
  logic [XLEN-1:0] cfg_wdata;
  logic [1:0]      priv_i;
  logic            xlen32_i;
  logic [XLEN-1:0] pc_i, data_addr_i;
  logic [7:0]      ctl_o;
  logic [XLEN-1:0] fetch_addr_o, data_addr_o;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  // bench-side model
  logic [7:0]  m_ctl;
  logic [63:0] m_mask [3];
  logic [63:0] m_base [3];
  logic        m_aen, m_aif;
  logic [63:0] m_amask, m_abase;

  always #4 clk = ~clk;

  ptr_mask_unit #(.XLEN(XLEN)) i_ptr_mask_unit (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .priv_i(priv_i), .xlen32_i(xlen32_i), .pc_i(pc_i), .data_addr_i(data_addr_i),
    .ctl_o(ctl_o), .fetch_addr_o(fetch_addr_o), .data_addr_o(data_addr_o)
  );

  function automatic int lvl_of(input logic [1:0] p);
    case (p)
      2'b11: return 0;
      2'b01: return 1;
      2'b00: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic logic [63:0] xf(input logic [63:0] a, input logic ap, input logic n32);
    if (ap)       return (a & ~m_amask) | m_abase;
    else if (n32) return a & LOW32;
    else          return a;
  endfunction

  task automatic model_reset();
    m_ctl = '0;
    for (int i = 0; i < 3; i++) begin m_mask[i] = '0; m_base[i] = '0; end
    m_aen = 0; m_aif = 0; m_amask = '1; m_abase = '0;
  endtask

  task automatic model_edge();
    int l;
    if (cfg_we) begin
      case (cfg_sel)
        3'd0: m_ctl = {2'b11, cfg_wdata[5:0]};
        3'd1, 3'd2, 3'd3: m_mask[cfg_sel - 3'd1] = cfg_wdata;
        3'd4, 3'd5, 3'd6: m_base[cfg_sel - 3'd4] = cfg_wdata;
        default: ;
      endcase
    end
    l = lvl_of(priv_i);
    if (l < 3 && m_ctl[l]) begin
      m_aen = 1; m_aif = m_ctl[3+l]; m_amask = m_mask[l]; m_abase = m_base[l];
    end else begin
      m_aen = 0; m_aif = 0; m_amask = '1; m_abase = '0;
    end
  endtask

  task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic step(input logic we, input logic [2:0] sel, input logic [63:0] wd,
                      input logic [1:0] pr, input logic n32, input logic [63:0] pc,
                      input logic [63:0] da, input string req);
    @(negedge clk);
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    priv_i = pr; xlen32_i = n32; pc_i = pc; data_addr_i = da;
    @(posedge clk);
    model_edge();
    #2;
    chk(req, "ctl", {56'd0, ctl_o}, {56'd0, m_ctl});
    chk(req, "fetch", fetch_addr_o, xf(pc, m_aif, n32));
    chk(req, "data", data_addr_o, xf(da, m_aen, n32));
  endtask

  localparam logic [63:0] PC_A = 64'hABCD_EF01_2345_6789;
  localparam logic [63:0] DA_A = 64'h1357_9BDF_0246_8ACE;

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7341));
    rst = 1; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
    priv_i = 2'b11; xlen32_i = 0; pc_i = 0; data_addr_i = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1 reset state: everything passes through
    step(0, 0, 0, 2'b11, 0, PC_A, DA_A, "R1");
    step(0, 0, 0, 2'b00, 0, PC_A, DA_A, "R1");

    // R11 per-level mask/base writes
    step(1, 3'd1, 64'hFF00_0000_0000_FFFF, 2'b11, 0, PC_A, DA_A, "R11");
    step(1, 3'd4, 64'h1200_0000_0000_0034, 2'b11, 0, PC_A, DA_A, "R11");
    step(1, 3'd2, 64'h0000_FFFF_0000_0000, 2'b11, 0, PC_A, DA_A, "R11");
    step(1, 3'd5, 64'h0000_5A5A_0000_0000, 2'b11, 0, PC_A, DA_A, "R11");
    step(1, 3'd3, 64'hFFFF_FFFF_FF00_0000, 2'b11, 0, PC_A, DA_A, "R11");
    step(1, 3'd6, 64'h0000_0000_0000_0000, 2'b11, 0, PC_A, DA_A, "R11");

    // R2 + R9: enable machine with fetch masking, takes effect at that edge
    step(1, 3'd0, 64'hFFFF_FFFF_FFFF_FF09, 2'b11, 0, PC_A, DA_A, "R2");
    // R3 machine masking of fetch
    step(0, 0, 0, 2'b11, 0, 64'h0123_4567_89AB_CDEF, DA_A, "R3");
    // R7 32-bit mode, masked: upper base bits survive
    step(0, 0, 0, 2'b11, 1, 64'hFFFF_FFFF_FFFF_FFFF, DA_A, "R7");

    // R4 supervisor enabled, instruction bit clear
    step(1, 3'd0, 64'h02, 2'b01, 0, PC_A, DA_A, "R4");
    step(0, 0, 0, 2'b01, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R4");
    // R6 not masked fetch in 32-bit mode truncates
    step(0, 0, 0, 2'b01, 1, PC_A, DA_A, "R6");

    // R5 user disabled, machine also disabled now
    step(0, 0, 0, 2'b00, 0, PC_A, DA_A, "R5");
    step(0, 0, 0, 2'b11, 1, PC_A, DA_A, "R5");

    // R8 unsupported privilege with all levels enabled + fetch masking
    step(1, 3'd0, 64'h3F, 2'b10, 0, PC_A, DA_A, "R8");
    step(0, 0, 0, 2'b10, 1, PC_A, DA_A, "R8");
    // R9 privilege change picked up at the next edge
    step(0, 0, 0, 2'b00, 0, PC_A, DA_A, "R9");
    step(0, 0, 0, 2'b01, 0, PC_A, DA_A, "R9");

    // R10 select 7 ignored
    step(1, 3'd7, 64'hDEAD_BEEF_DEAD_BEEF, 2'b01, 0, PC_A, DA_A, "R10");
    step(1, 3'd7, 64'h0, 2'b11, 0, PC_A, DA_A, "R10");

    // R2 instruction bits retained, forced bits on zero write
    step(1, 3'd0, 64'h0, 2'b11, 0, PC_A, DA_A, "R2");
    step(1, 3'd0, 64'h38, 2'b11, 0, PC_A, DA_A, "R2");

    // R9 mixed random traffic
    for (int i = 0; i < 600; i++) begin
      logic [2:0]  s;
      logic [63:0] w;
      s = 3'($urandom_range(0, 7));
      w = {$urandom(), $urandom()};
      if (s == 3'd0) w = 64'($urandom_range(0, 255));
      step($urandom_range(0, 3) == 0, s, w, 2'($urandom_range(0, 3)),
           1'($urandom_range(0, 1)), {$urandom(), $urandom()}, {$urandom(), $urandom()}, "R9");
    end

    // R1 reset again from a busy state
    @(negedge clk); rst = 1; cfg_we = 0;
    @(posedge clk); model_reset();
    @(negedge clk); rst = 0;
    step(0, 0, 0, 2'b11, 0, PC_A, DA_A, "R1");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule